// File: doc/BRIEF.md
# Banked Address Decoder for an 8-bit Processor

This block sits between an 8-bit processor and its memories and peripherals. It turns the 16-bit memory address into one-hot chip selects for a fixed program ROM, a switchable ROM window, work RAM, two palette RAM halves and three video RAMs. It also turns the processor's I/O cycles into reads of four DIP switch banks and three input ports, and into write strobes for a sound chip.

A 3-bit bank register is loaded by an I/O write and picks which 16 KiB page of ROM the window at 0x8000 shows. The block produces the physical ROM address for both the fixed area and the window, so the ROM device needs no decode of its own. The memories and the sound chip themselves are outside this block.

Top module: `banked_addr_decoder`

## Requirements
- R1: A memory read at 0x0000..0x7FFF drives select bit 0 (fixed ROM) and the ROM address equals the processor address.
- R2: A memory read at 0x8000..0xBFFF drives select bit 1 (ROM window) and the ROM address is 0x10000 + bank*0x4000 + (address & 0x3FFF).
- R3: A memory read or write drives select bit 2 for 0xC000..0xC7FF (work RAM), bit 3 for 0xC800..0xCBFF and bit 4 for 0xCC00..0xCFFF (palette halves), bit 5 for 0xD000..0xD7FF (low code RAM), bit 6 for 0xD800..0xDFFF (high code RAM) and bit 7 for 0xE000..0xE7FF (colour RAM).
- R4: At most one select is active at any time; none is active without a read or write strobe, for any access to 0xE800..0xFFFF, or for a write to either ROM area.
- R5: The bank register resets to 0 and, on the clock edge of an I/O write whose low address byte is 0xA0, loads data bits 2..0; the upper I/O address byte and upper data bits are ignored.
- R6: An I/O read returns the raw, active-low pin level (a pressed input reads 0) of DIP bank k (bits 8k+7..8k of the DIP input) at low byte 0x00, 0x20, 0x40, 0x60 for k = 0..3, and of input port 0, 1, 2 at 0x80, 0xA0, 0xE0; every other low byte, and any cycle without an I/O read, returns 0xFF.
- R7: An I/O write with low byte 0x40 or 0x41 pulses the sound write strobe, with the register-select output equal to address bit 0 (0 = address register, 1 = data register); I/O reads and writes elsewhere leave it low.
- R8: I/O reads at 0xA0 and I/O writes at any other low byte leave the bank register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_addr_i | input | 16 | Memory address |
| mem_rd_i | input | 1 | Memory read strobe |
| mem_wr_i | input | 1 | Memory write strobe |
| io_addr_i | input | 16 | I/O address (only low byte decoded) |
| io_rd_i | input | 1 | I/O read strobe |
| io_wr_i | input | 1 | I/O write strobe |
| io_wdata_i | input | 8 | I/O write data |
| dip_i | input | 32 | Four DIP banks, active low |
| port_i | input | 24 | Three input ports, active low |
| mem_sel_o | output | 8 | One-hot memory chip selects |
| rom_addr_o | output | 18 | Physical ROM address |
| io_rdata_o | output | 8 | I/O read data |
| snd_wr_o | output | 1 | Sound chip write strobe |
| snd_a0_o | output | 1 | Sound chip register select |

## Verification
The bench sweeps the whole memory space for reads and for writes and compares every select against an independently written range table, so a region boundary off by one page or a ROM select leaking on writes shows up as a wrong or double select. It loads every bank value, with noise in the upper address and data bits, and checks the window address at the start, middle and end of the page; a wrong base, step or page mask gives a wrong ROM address. It checks that 0xA0 and 0x40 route reads and writes to different targets, so a decoder that loaded the bank on a read or strobed the sound chip on a read would be caught, as would unmapped I/O reads returning anything but 0xFF.

// File: rtl/addr_dec_pkg.sv
package addr_dec_pkg;
  localparam int N_REGION  = 8;
  localparam int N_ROM_REG = 2;  // regions 0..N_ROM_REG-1 are read-only

  function automatic logic [15:0] region_base(int i);
    case (i)
      0: return 16'h0000;
      1: return 16'h8000;
      2: return 16'hC000;
      3: return 16'hC800;
      4: return 16'hCC00;
      5: return 16'hD000;
      6: return 16'hD800;
      default: return 16'hE000;
    endcase
  endfunction

  function automatic logic [15:0] region_span(int i);
    case (i)
      0: return 16'h7FFF;
      1: return 16'h3FFF;
      3, 4: return 16'h03FF;
      default: return 16'h07FF;
    endcase
  endfunction

  function automatic logic [7:0] port_addr(int j);
    case (j)
      0: return 8'h80;
      1: return 8'hA0;
      default: return 8'hE0;
    endcase
  endfunction

  localparam logic [7:0] BANK_IO = 8'hA0;
  localparam logic [6:0] SND_IO  = 7'h20;  // 0x40/0x41
  localparam int         DIP_STEP = 32;
endpackage

// File: rtl/mem_region_dec.sv
module mem_region_dec
  import addr_dec_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                rd_i,
  input  logic                wr_i,
  output logic [N_REGION-1:0] sel_o
);
  for (genvar i = 0; i < N_REGION; i++) begin : g_reg
    logic hit;
    assign hit = (addr_i & ~ADDR_W'(region_span(i))) == ADDR_W'(region_base(i));
    if (i < N_ROM_REG) begin : g_ro
      assign sel_o[i] = hit && rd_i;
    end else begin : g_rw
      assign sel_o[i] = hit && (rd_i || wr_i);
    end
  end
endmodule

// File: rtl/rom_bank_map.sv
module rom_bank_map #(
  parameter int ADDR_W   = 16,
  parameter int BANK_W   = 3,
  parameter int WIN_AW   = 14,
  parameter int ROM_AW   = 18,
  parameter int WIN_BASE = 'h10000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_i,
  input  logic [BANK_W-1:0] bank_d_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [BANK_W-1:0] bank_q_o,
  output logic [ROM_AW-1:0] rom_addr_o
);
  localparam int FIX_AW = ADDR_W - 1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   bank_q_o <= '0;
    else if (ld_i) bank_q_o <= bank_d_i;
  end

  logic [ROM_AW-1:0] win_addr;
  assign win_addr = ROM_AW'(WIN_BASE)
                  + (ROM_AW'(bank_q_o) << WIN_AW)
                  + ROM_AW'(addr_i[WIN_AW-1:0]);

  assign rom_addr_o = addr_i[ADDR_W-1] ? win_addr : ROM_AW'(addr_i[FIX_AW-1:0]);
endmodule

// File: rtl/io_port_dec.sv
module io_port_dec
  import addr_dec_pkg::*;
#(
  parameter int DW     = 8,
  parameter int N_DIP  = 4,
  parameter int N_PORT = 3,
  parameter int BANK_W = 3
) (
  input  logic [7:0]           addr_i,
  input  logic                 rd_i,
  input  logic                 wr_i,
  input  logic [DW-1:0]        wdata_i,
  input  logic [N_DIP*DW-1:0]  dip_i,
  input  logic [N_PORT*DW-1:0] port_i,
  output logic [DW-1:0]        rdata_o,
  output logic                 bank_ld_o,
  output logic [BANK_W-1:0]    bank_d_o,
  output logic                 snd_wr_o,
  output logic                 snd_a0_o
);
  always_comb begin
    rdata_o = '1;
    if (rd_i) begin
      for (int k = 0; k < N_DIP; k++)
        if (addr_i == 8'(k * DIP_STEP)) rdata_o = dip_i[k*DW +: DW];
      for (int j = 0; j < N_PORT; j++)
        if (addr_i == port_addr(j)) rdata_o = port_i[j*DW +: DW];
    end
  end

  assign bank_ld_o = wr_i && (addr_i == BANK_IO);
  assign bank_d_o  = wdata_i[BANK_W-1:0];
  assign snd_wr_o  = wr_i && (addr_i[7:1] == SND_IO);
  assign snd_a0_o  = addr_i[0];
endmodule

// File: rtl/banked_addr_decoder.sv
module banked_addr_decoder
  import addr_dec_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DW       = 8,
  parameter int BANK_W   = 3,
  parameter int WIN_AW   = 14,
  parameter int ROM_AW   = 18,
  parameter int WIN_BASE = 'h10000,
  parameter int N_DIP    = 4,
  parameter int N_PORT   = 3
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [ADDR_W-1:0]    mem_addr_i,
  input  logic                 mem_rd_i,
  input  logic                 mem_wr_i,
  input  logic [ADDR_W-1:0]    io_addr_i,
  input  logic                 io_rd_i,
  input  logic                 io_wr_i,
  input  logic [DW-1:0]        io_wdata_i,
  input  logic [N_DIP*DW-1:0]  dip_i,
  input  logic [N_PORT*DW-1:0] port_i,
  output logic [N_REGION-1:0]  mem_sel_o,
  output logic [ROM_AW-1:0]    rom_addr_o,
  output logic [DW-1:0]        io_rdata_o,
  output logic                 snd_wr_o,
  output logic                 snd_a0_o
);
  logic              bank_ld;
  logic [BANK_W-1:0] bank_d, bank_q;

  mem_region_dec #(.ADDR_W(ADDR_W)) u_mem (
    .addr_i(mem_addr_i), .rd_i(mem_rd_i), .wr_i(mem_wr_i), .sel_o(mem_sel_o)
  );

  io_port_dec #(.DW(DW), .N_DIP(N_DIP), .N_PORT(N_PORT), .BANK_W(BANK_W)) u_io (
    .addr_i(io_addr_i[7:0]), .rd_i(io_rd_i), .wr_i(io_wr_i), .wdata_i(io_wdata_i),
    .dip_i(dip_i), .port_i(port_i), .rdata_o(io_rdata_o),
    .bank_ld_o(bank_ld), .bank_d_o(bank_d), .snd_wr_o(snd_wr_o), .snd_a0_o(snd_a0_o)
  );

  rom_bank_map #(.ADDR_W(ADDR_W), .BANK_W(BANK_W), .WIN_AW(WIN_AW),
                 .ROM_AW(ROM_AW), .WIN_BASE(WIN_BASE)) u_bank (
    .clk_i(clk_i), .rst_ni(rst_ni), .ld_i(bank_ld), .bank_d_i(bank_d),
    .addr_i(mem_addr_i), .bank_q_o(bank_q), .rom_addr_o(rom_addr_o)
  );

  a_r4_onehot_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(mem_sel_o));
  a_r4_no_strobe_no_sel: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_rd_i && !mem_wr_i) |-> (mem_sel_o == '0));
  a_r1_fix_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_sel_o[0] |-> (rom_addr_o == ROM_AW'(mem_addr_i)));
  a_r2_win_above_base: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_sel_o[1] |-> (rom_addr_o >= ROM_AW'(WIN_BASE)));
  a_r5_bank_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (io_wr_i && io_addr_i[7:0] == BANK_IO) |=> (bank_q == $past(io_wdata_i[BANK_W-1:0])));
  a_r8_bank_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(io_wr_i && io_addr_i[7:0] == BANK_IO) |=> $stable(bank_q));
  a_r7_no_snd_on_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !io_wr_i |-> !snd_wr_o);
endmodule

// File: tb/banked_addr_decoder_tb.sv
module banked_addr_decoder_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] mem_addr = '0, io_addr = '0;
  logic        mem_rd = 1'b0, mem_wr = 1'b0, io_rd = 1'b0, io_wr = 1'b0;
  logic [7:0]  io_wdata = '0;
  logic [31:0] dip = 32'h7E_BD_DB_E7;
  logic [23:0] port = 24'hF0_5A_0F;
  logic [7:0]  sel;
  logic [17:0] rom_addr;
  logic [7:0]  rdata;
  logic        snd_wr, snd_a0;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  banked_addr_decoder u_dut (
    .clk_i(clk), .rst_ni(rst_n), .mem_addr_i(mem_addr), .mem_rd_i(mem_rd), .mem_wr_i(mem_wr),
    .io_addr_i(io_addr), .io_rd_i(io_rd), .io_wr_i(io_wr), .io_wdata_i(io_wdata),
    .dip_i(dip), .port_i(port), .mem_sel_o(sel), .rom_addr_o(rom_addr),
    .io_rdata_o(rdata), .snd_wr_o(snd_wr), .snd_a0_o(snd_a0)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_sel(int a, bit rd, bit wr);
    bit any = rd || wr;
    if (a < 'h8000)      return rd  ? 8'h01 : 8'h00;
    else if (a < 'hC000) return rd  ? 8'h02 : 8'h00;
    else if (a < 'hC800) return any ? 8'h04 : 8'h00;
    else if (a < 'hCC00) return any ? 8'h08 : 8'h00;
    else if (a < 'hD000) return any ? 8'h10 : 8'h00;
    else if (a < 'hD800) return any ? 8'h20 : 8'h00;
    else if (a < 'hE000) return any ? 8'h40 : 8'h00;
    else if (a < 'hE800) return any ? 8'h80 : 8'h00;
    return 8'h00;
  endfunction

  task automatic io_write(logic [15:0] a, logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0;
  endtask

  task automatic win_check(string req, int bank);
    int offs[3] = '{0, 'h1234, 'h3FFF};
    foreach (offs[i]) begin
      mem_addr = 16'('h8000 + offs[i]); mem_rd = 1'b1; #1;
      chk(req, rom_addr, 'h10000 + bank * 'h4000 + offs[i]);
    end
    mem_rd = 1'b0;
  endtask

  task automatic t_reset;
    #1;
    chk("R4 idle sel", sel, 0);
    chk("R6 idle rdata", rdata, 8'hFF);
    chk("R7 idle snd", snd_wr, 0);
    win_check("R5 reset bank 0", 0);
  endtask

  task automatic t_sweep;
    for (int a = 0; a < 'h10000; a += 'h80) begin
      for (int m = 0; m < 3; m++) begin
        mem_addr = 16'(a); mem_rd = (m == 1); mem_wr = (m == 2); #1;
        chk(m == 2 ? "R4 write sel" : "R3 sel", sel, exp_sel(a, m == 1, m == 2));
        if (m == 1 && a < 'h8000) chk("R1 fix addr", rom_addr, a);
      end
    end
    for (int a = 'hE7FF; a <= 'hE800; a++) begin
      mem_addr = 16'(a); mem_rd = 1'b1; mem_wr = 1'b0; #1;
      chk("R4 top edge", sel, exp_sel(a, 1, 0));
    end
    mem_addr = 16'h7FFF; #1; chk("R1 last fix", rom_addr, 'h7FFF);
    mem_addr = 16'hC7FF; #1; chk("R3 wram end", sel, 8'h04);
    mem_addr = 16'hCBFF; #1; chk("R3 pal a end", sel, 8'h08);
    mem_rd = 1'b0; mem_wr = 1'b0;
  endtask

  task automatic t_window;
    for (int b = 0; b < 8; b++) begin
      io_write(16'h5500 | 16'hA0, 8'hA8 | 8'(b));
      win_check("R2 window", b);
      mem_addr = 16'h9000; mem_rd = 1'b1; #1; chk("R2 win sel", sel, 8'h02); mem_rd = 1'b0;
    end
  endtask

  task automatic t_io_read;
    logic [7:0] addrs[8] = '{8'h00, 8'h20, 8'h40, 8'h60, 8'h80, 8'hA0, 8'hE0, 8'hC0};
    logic [7:0] exps[8];
    exps = '{dip[7:0], dip[15:8], dip[23:16], dip[31:24], port[7:0], port[15:8], port[23:16], 8'hFF};
    foreach (addrs[i]) begin
      @(negedge clk); io_addr = {8'h3C, addrs[i]}; io_rd = 1'b1; #1;
      chk("R6 io read", rdata, exps[i]);
    end
    io_addr = 16'h0041; #1; chk("R6 unmapped 41", rdata, 8'hFF);
    io_addr = 16'h0001; #1; chk("R6 unmapped 01", rdata, 8'hFF);
    port[15] = 1'b0; io_addr = 16'h00A0; #1; chk("R6 active low pin", rdata[7], 0);
    port[15] = 1'b1;
    io_rd = 1'b0; #1; chk("R6 no read ff", rdata, 8'hFF);
  endtask

  task automatic t_sound;
    @(negedge clk); io_addr = 16'h7740; io_wdata = 8'h12; io_wr = 1'b1; #1;
    chk("R7 snd strobe addr", snd_wr, 1); chk("R7 a0=0", snd_a0, 0);
    io_addr = 16'h0041; #1;
    chk("R7 snd strobe data", snd_wr, 1); chk("R7 a0=1", snd_a0, 1);
    io_addr = 16'h0042; #1; chk("R7 no strobe 42", snd_wr, 0);
    io_addr = 16'h00A0; io_wdata = 8'h02; #1; chk("R7 no strobe a0", snd_wr, 0);
    @(negedge clk); io_wr = 1'b0; io_addr = 16'h0040; io_rd = 1'b1; #1;
    chk("R7 read no strobe", snd_wr, 0); chk("R7 read dip", rdata, dip[23:16]);
    @(negedge clk); io_rd = 1'b0;
    win_check("R5 bank from a0 write", 2);
  endtask

  task automatic t_bank_isolation;
    io_write(16'h00A0, 8'h05);
    @(negedge clk); io_addr = 16'h00A0; io_rd = 1'b1;
    @(negedge clk); io_rd = 1'b0;
    win_check("R8 read a0 holds", 5);
    io_write(16'h00A1, 8'h03);
    io_write(16'h0040, 8'h03);
    io_write(16'h0080, 8'h03);
    io_write(16'hA000, 8'h03);
    win_check("R8 other writes hold", 5);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_sweep();
    t_window();
    t_io_read();
    t_sound();
    t_bank_isolation();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule